// File: doc/BRIEF.md
# Flash Protected-Range Access Guard

This block checks every flash access before the cycle engine is allowed to start it. It holds a small set of programmable window registers. Each window has a 4 KiB-aligned start page, an inclusive end page, and its own read-guard and write-guard enables. An access is described by its kind, its start byte address and its byte count minus one. The block compares the whole byte span of the access against every window in parallel. One cycle later it either grants the access or refuses it. A refusal also sets an error flag that stays set.

Configuration software writes the windows through a simple indexed write port and can read them back through the same index. A lock input freezes the windows until the next reset. Accesses are still checked after the lock is set.

Top module: `fpr_guard`

## Requirements
- R1: A window word has this layout: start page in bits 12:0, read-guard enable in bit 15, end page in bits 28:16, write-guard enable in bit 31. All other bits are not stored and read back as zero. The windows change only on a write.
- R2: A write whose index is NUM_RANGES or larger changes no window. A read-back at such an index returns zero.
- R3: A window covers byte addresses from start*4096 through end*4096+4095, both inclusive. A window whose end page is below its start page covers nothing.
- R4: A window whose stored word is all zero is unused and blocks nothing.
- R5: Access kind encoding is 00 read, 01 write, 10 erase, 11 treated as write. A read is refused only by windows with the read-guard set. Every other kind is refused only by windows with the write-guard set.
- R6: The access span is acc_addr through acc_addr+acc_len_m1. The access is refused if any byte of the span lies in a qualifying window.
- R7: For each cycle with acc_valid high, exactly one of acc_go or acc_denied is high for the single following cycle. Neither is high after a cycle without acc_valid.
- R8: err_sticky rises together with acc_denied and stays high until reset.
- R9: cfg_lock raises cfg_locked from the next cycle until reset. A window write in the same cycle as cfg_lock still takes effect. Later writes are ignored. Access checking continues while locked.
- R10: After reset every window reads zero, cfg_locked is low, and acc_go, acc_denied and err_sticky are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write cfg_wdata into the window at cfg_idx |
| cfg_idx | input | IDX_W (3) | Window index for write and read-back |
| cfg_wdata | input | 32 | Window word to write |
| cfg_lock | input | 1 | Freeze the windows until reset |
| cfg_rdata | output | 32 | Window word at cfg_idx (combinational) |
| cfg_locked | output | 1 | Lock state |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | Access kind: 00 read, 01 write, 10 erase |
| acc_addr | input | 25 | First byte address |
| acc_len_m1 | input | LEN_W (6) | Byte count minus one |
| acc_go | output | 1 | Access granted (one cycle after acc_valid) |
| acc_denied | output | 1 | Access refused, one-cycle pulse |
| err_sticky | output | 1 | A refusal has occurred since reset |

## Verification
The bench builds the block with its defaults: five windows and a 6-bit length field, so one access spans up to 64 bytes. Five windows are enough to hold, at the same time, a write-only window, a one-page read-only window, an inverted (empty) window, an unused slot and a window at the very top page. With the 64-byte span, an access can start one byte below a window and end inside it. The three-bit index also leaves codes 5 to 7 free, which exercises the handling of out-of-range indices.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  localparam int GRAN_SHIFT = 12;
  localparam int PG_W       = 13;
  localparam int ADDR_W     = PG_W + GRAN_SHIFT;
  localparam int WORD_W     = 32;
  localparam int START_LSB  = 0;
  localparam int RDEN_BIT   = 15;
  localparam int END_LSB    = 16;
  localparam int WREN_BIT   = 31;

  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_ERASE = 2'b10,
    KIND_OTHER = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic            wr_guard;
    logic [PG_W-1:0] end_pg;
    logic            rd_guard;
    logic [PG_W-1:0] start_pg;
  } window_t;

  function automatic logic [WORD_W-1:0] window_to_word(window_t w);
    logic [WORD_W-1:0] v;
    v = '0;
    v[START_LSB +: PG_W] = w.start_pg;
    v[RDEN_BIT]          = w.rd_guard;
    v[END_LSB +: PG_W]   = w.end_pg;
    v[WREN_BIT]          = w.wr_guard;
    return v;
  endfunction

  function automatic window_t word_to_window(logic [WORD_W-1:0] v);
    window_t w;
    w.start_pg = v[START_LSB +: PG_W];
    w.rd_guard = v[RDEN_BIT];
    w.end_pg   = v[END_LSB +: PG_W];
    w.wr_guard = v[WREN_BIT];
    return w;
  endfunction

  // Span [lo, hi] of pages against window [s, e]; hi carries one extra bit.
  function automatic logic pages_overlap(logic [PG_W-1:0] lo, logic [PG_W:0] hi,
                                         logic [PG_W-1:0] s, logic [PG_W-1:0] e);
    return (s <= e) && (lo <= e) && (hi >= {1'b0, s});
  endfunction

endpackage

// File: rtl/fpr_window_bank.sv
module fpr_window_bank
  import fpr_pkg::*;
#(
  parameter int NUM_RANGES = 5,
  localparam int IDX_W = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             idx,
  input  logic [WORD_W-1:0]            wdata,
  input  logic                         lock_req,
  output logic [WORD_W-1:0]            rdata,
  output logic                         locked,
  output window_t [NUM_RANGES-1:0]     windows
);

  logic wr_open;
  assign wr_open = wr_en && !locked;

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        windows[g] <= '0;
      end else if (wr_open && (idx == IDX_W'(g))) begin
        windows[g] <= word_to_window(wdata);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
    end else if (lock_req) begin
      locked <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_RANGES; i++) begin
      if (idx == IDX_W'(i)) begin
        rdata = window_to_word(windows[i]);
      end
    end
  end

endmodule

// File: rtl/fpr_window_match.sv
module fpr_window_match
  import fpr_pkg::*;
(
  input  window_t          win,
  input  logic             is_read,
  input  logic [PG_W-1:0]  lo_pg,
  input  logic [PG_W:0]    hi_pg,
  output logic             hit
);

  logic in_use;
  logic armed;

  assign in_use = (window_to_word(win) != '0);
  assign armed  = is_read ? win.rd_guard : win.wr_guard;
  assign hit    = in_use && armed &&
                  pages_overlap(lo_pg, hi_pg, win.start_pg, win.end_pg);

endmodule

// File: rtl/fpr_verdict.sv
module fpr_verdict (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_valid,
  input  logic hit_any,
  output logic acc_go,
  output logic acc_denied,
  output logic err_sticky
);

  logic refuse_now;
  assign refuse_now = acc_valid && hit_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_go     <= 1'b0;
      acc_denied <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      acc_go     <= acc_valid && !hit_any;
      acc_denied <= refuse_now;
      err_sticky <= err_sticky || refuse_now;
    end
  end

endmodule

// File: rtl/fpr_guard.sv
module fpr_guard
  import fpr_pkg::*;
#(
  parameter int NUM_RANGES = 5,
  parameter int LEN_W      = 6,
  localparam int IDX_W = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [WORD_W-1:0]  cfg_wdata,
  input  logic               cfg_lock,
  output logic [WORD_W-1:0]  cfg_rdata,
  output logic               cfg_locked,
  input  logic               acc_valid,
  input  logic [1:0]         acc_kind,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [LEN_W-1:0]   acc_len_m1,
  output logic               acc_go,
  output logic               acc_denied,
  output logic               err_sticky
);

  localparam int FLAT_W = NUM_RANGES * WORD_W;

  function automatic logic [ADDR_W:0] span_last(logic [ADDR_W-1:0] a,
                                                logic [LEN_W-1:0] n);
    return {1'b0, a} + (ADDR_W+1)'(n);
  endfunction

  window_t [NUM_RANGES-1:0] windows;
  logic    [NUM_RANGES-1:0] hit_vec;
  logic    [ADDR_W:0]       last_byte;
  logic    [PG_W-1:0]       lo_pg;
  logic    [PG_W:0]         hi_pg;
  logic                     is_read;
  logic                     hit_any;
  logic    [FLAT_W-1:0]     window_flat;

  fpr_window_bank #(.NUM_RANGES(NUM_RANGES)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .idx      (cfg_idx),
    .wdata    (cfg_wdata),
    .lock_req (cfg_lock),
    .rdata    (cfg_rdata),
    .locked   (cfg_locked),
    .windows  (windows)
  );

  assign last_byte = span_last(acc_addr, acc_len_m1);
  assign lo_pg     = acc_addr[ADDR_W-1:GRAN_SHIFT];
  assign hi_pg     = last_byte[ADDR_W:GRAN_SHIFT];
  assign is_read   = (acc_kind == KIND_READ);

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_match
    fpr_window_match u_match (
      .win     (windows[g]),
      .is_read (is_read),
      .lo_pg   (lo_pg),
      .hi_pg   (hi_pg),
      .hit     (hit_vec[g])
    );
    assign window_flat[g*WORD_W +: WORD_W] = window_to_word(windows[g]);
  end

  assign hit_any = |hit_vec;

  fpr_verdict u_verdict (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .hit_any    (hit_any),
    .acc_go     (acc_go),
    .acc_denied (acc_denied),
    .err_sticky (err_sticky)
  );

endmodule

// File: rtl/fpr_guard_chk.sv
module fpr_guard_chk #(
  parameter int FLAT_W = 160
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              hit_any,
  input logic              acc_go,
  input logic              acc_denied,
  input logic              err_sticky,
  input logic              cfg_locked,
  input logic              cfg_wr_en,
  input logic [FLAT_W-1:0] window_flat
);

  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_go && acc_denied));

  assert_respond_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (acc_go || acc_denied));

  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!acc_go && !acc_denied));

  assert_refuse_on_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && hit_any) |=> acc_denied);

  assert_grant_on_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !hit_any) |=> acc_go);

  assert_sticky_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_denied |-> err_sticky);

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_locked |=> cfg_locked);

  assert_lock_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_locked |=> $stable(window_flat));

  assert_no_write_no_change_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_en |=> $stable(window_flat));

endmodule

bind fpr_guard fpr_guard_chk #(.FLAT_W(FLAT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .hit_any     (hit_any),
  .acc_go      (acc_go),
  .acc_denied  (acc_denied),
  .err_sticky  (err_sticky),
  .cfg_locked  (cfg_locked),
  .cfg_wr_en   (cfg_wr_en),
  .window_flat (window_flat)
);

// File: tb/fpr_guard_tb.sv
module fpr_guard_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NR   = 5;
  localparam int LW   = 6;
  localparam int IW   = 3;
  localparam int AW   = 25;
  localparam int NVEC = 17;

  // {kind[1:0], addr[24:0], len_m1[5:0], expect_refuse}
  localparam logic [33:0] VEC [NVEC] = '{
    {2'd0, 25'h0010000, 6'd0,  1'b0},
    {2'd1, 25'h0010000, 6'd0,  1'b1},
    {2'd2, 25'h001FFFF, 6'd0,  1'b1},
    {2'd1, 25'h0020000, 6'd0,  1'b0},
    {2'd1, 25'h000FFFF, 6'd0,  1'b0},
    {2'd1, 25'h000FFF0, 6'd31, 1'b1},
    {2'd0, 25'h0100000, 6'd0,  1'b1},
    {2'd0, 25'h00FFFC0, 6'd63, 1'b0},
    {2'd0, 25'h00FFFC1, 6'd63, 1'b1},
    {2'd1, 25'h0100800, 6'd0,  1'b0},
    {2'd0, 25'h0050000, 6'd0,  1'b0},
    {2'd1, 25'h004F000, 6'd0,  1'b0},
    {2'd0, 25'h1FFF000, 6'd0,  1'b1},
    {2'd1, 25'h1FFFFC0, 6'd63, 1'b1},
    {2'd0, 25'h1FFEFC0, 6'd63, 1'b0},
    {2'd3, 25'h0010000, 6'd0,  1'b1},
    {2'd0, 25'h0000000, 6'd0,  1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          cfg_lock = 1'b0;
  logic [31:0]   cfg_rdata;
  logic          cfg_locked;
  logic          acc_valid = 1'b0;
  logic [1:0]    acc_kind = '0;
  logic [AW-1:0] acc_addr = '0;
  logic [LW-1:0] acc_len_m1 = '0;
  logic          acc_go;
  logic          acc_denied;
  logic          err_sticky;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpr_guard #(.NUM_RANGES(NR), .LEN_W(LW)) u_dut (
    .clk (clk), .rst_n (rst_n),
    .cfg_wr_en (cfg_wr_en), .cfg_idx (cfg_idx), .cfg_wdata (cfg_wdata),
    .cfg_lock (cfg_lock), .cfg_rdata (cfg_rdata), .cfg_locked (cfg_locked),
    .acc_valid (acc_valid), .acc_kind (acc_kind), .acc_addr (acc_addr),
    .acc_len_m1 (acc_len_m1), .acc_go (acc_go), .acc_denied (acc_denied),
    .err_sticky (err_sticky)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic write_win(int idx, logic [31:0] w, bit lock);
    @(negedge clk);
    cfg_idx = IW'(idx); cfg_wdata = w; cfg_wr_en = 1'b1; cfg_lock = lock;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_lock = 1'b0;
  endtask

  task automatic read_win(int idx, output logic [31:0] w);
    cfg_idx = IW'(idx);
    #1;
    w = cfg_rdata;
  endtask

  task automatic access(logic [1:0] k, logic [AW-1:0] a, logic [LW-1:0] n,
                        output logic go, output logic den);
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = k; acc_addr = a; acc_len_m1 = n;
    @(negedge clk);
    acc_valid = 1'b0;
    go = acc_go; den = acc_denied;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [31:0] w;
    logic go, den;
    do_reset();
    @(negedge clk);

    // R10 reset state
    for (int i = 0; i < NR; i++) begin
      read_win(i, w);
      check("R10 window after reset", w, 32'h0);
    end
    check("R10 locked after reset", 32'(cfg_locked), 32'h0);
    check("R10 go/denied/sticky after reset",
          {29'h0, acc_go, acc_denied, err_sticky}, 32'h0);

    // R1 layout and unstored bits
    write_win(3, 32'hFFFF_FFFF, 1'b0);
    read_win(3, w);
    check("R1 unstored bits read zero", w, 32'h9FFF_9FFF);
    write_win(3, 32'h0, 1'b0);

    // R2 out-of-range index
    write_win(7, 32'h9FFF_9FFF, 1'b0);
    read_win(7, w);
    check("R2 read at index 7", w, 32'h0);
    for (int i = 0; i < NR; i++) begin
      read_win(i, w);
      check("R2 no window changed", w, 32'h0);
    end

    // program windows
    write_win(0, 32'h801F_0010, 1'b0);
    write_win(1, 32'h0100_8100, 1'b0);
    write_win(2, 32'h804F_8050, 1'b0);
    write_win(4, 32'h9FFF_9FFF, 1'b0);
    read_win(1, w);
    check("R1 readback window 1", w, 32'h0100_8100);

    // R3 R4 R5 R6 R7 vector walk
    for (int v = 0; v < NVEC; v++) begin
      access(VEC[v][33:32], VEC[v][31:7], VEC[v][6:1], go, den);
      check($sformatf("R3/R5/R6 vector %0d refuse", v), 32'(den), 32'(VEC[v][0]));
      check($sformatf("R7 vector %0d grant", v), 32'(go), 32'(!VEC[v][0]));
      if (v == 0) check("R8 sticky low before refusal", 32'(err_sticky), 32'h0);
      @(negedge clk);
      check($sformatf("R7 vector %0d pulse ends", v), {30'h0, acc_go, acc_denied}, 32'h0);
    end
    check("R8 sticky after refusals", 32'(err_sticky), 32'h1);

    // R9 lock with same-cycle write
    write_win(3, 32'h0003_8003, 1'b1);
    check("R9 locked", 32'(cfg_locked), 32'h1);
    read_win(3, w);
    check("R9 same-cycle write kept", w, 32'h0003_8003);
    write_win(3, 32'h0, 1'b0);
    read_win(3, w);
    check("R9 write after lock ignored", w, 32'h0003_8003);
    access(2'd0, 25'h0003010, 6'd0, go, den);
    check("R9 checking while locked", 32'(den), 32'h1);
    check("R8 sticky held", 32'(err_sticky), 32'h1);

    // R10 reset clears lock and windows
    do_reset();
    @(negedge clk);
    read_win(3, w);
    check("R10 window cleared by reset", w, 32'h0);
    check("R10 lock cleared by reset", 32'(cfg_locked), 32'h0);
    check("R10 sticky cleared by reset", 32'(err_sticky), 32'h0);

    finished = 1'b1;
    report();
  end

endmodule